// File: doc/BRIEF.md
# Output Driver Impedance Update Sequencer

This block owns the impedance code that sets the strength of a memory device's data output drivers. A separate measurement circuit converts an external precision resistor into a requested code, with the requested impedance being one fifth of that resistor. The sequencer walks the active code toward the requested value one unit at a time. It changes the code only in clock cycles where the data outputs are not driving. Examples of such cycles are write cycles, deselected cycles, and cycles where the output enable is held inactive with proper setup around the clock.

Code 0 is the strongest driver, which is the lowest impedance. The all-ones code is the weakest driver, which is the highest impedance. Power-up reset puts the active code at 0. When the reference pin is left open or tied high, the request is forced to the all-ones code. The requested code passes through a configurable number of register stages before it takes effect.

Each step is followed by a quiet interval of `STEP_GAP` cycles. The default values bound the full walk from code 0 to the all-ones code at 2048 cycles when the outputs are always in high impedance.

Top module: `zq_imp_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `code_o` is 0 (lowest impedance). It stays 0 until an allowed step occurs.
- R2: `code_o` changes only after a clock edge at which `hiz_i` was sampled high.
- R3: Every change of `code_o` has a magnitude of exactly one code unit.
- R4: A change moves `code_o` toward the effective requested code and never past it. An increase happens only when the request is above the code, and a decrease only when it is below.
- R5: After a change of `code_o`, at least `STEP_GAP` clock edges pass before the next change. The default gap is 8.
- R6: While `ref_open_i` is high, the requested code is taken as all ones (255 at the default 8-bit width), whatever `tgt_code_i` holds.
- R7: A new value of `tgt_code_i` or `ref_open_i` reaches the effective request after `SYNC_STAGES` clock edges. The default is 2. Before then, `done_o` and the step direction use the older value.
- R8: `done_o` is high exactly when `code_o` equals the effective request.
- R9: From reset, with `hiz_i` held high and the request at all ones, `done_o` rises within 2048 clock cycles of reset release.
- R10: While `code_o` equals the effective request, `code_o` holds, even when `hiz_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| hiz_i | input | 1 | High when the data outputs are in high impedance this cycle |
| ref_open_i | input | 1 | High when the reference pin is open or tied high |
| tgt_code_i | input | 8 | Requested impedance code from the measurement circuit |
| code_o | output | 8 | Active impedance code sent to the output drivers |
| done_o | output | 1 | Active code equals the effective request |

## Verification
Two events can meet on the same clock edge. One is a step that is granted from the old effective request. The other is a new request arriving at the end of the register chain, possibly in the opposite direction. The bench provokes this by changing `tgt_code_i` while `hiz_i` toggles at random and the gap counter is expiring. A behavioural model applies the same rules on every edge: the request as registered before the edge decides the direction, and the pipeline shift takes effect after it. The code and the done flag are then compared against this model every cycle.

// File: rtl/zq_imp_pkg.sv
package zq_imp_pkg;
   function automatic int unsigned zq_walk_cycles(int unsigned code_w,
                                                  int unsigned gap,
                                                  int unsigned stages);
      return stages + 1 + ((2 ** code_w) - 2) * gap;
   endfunction
endpackage

// File: rtl/zq_tgt_sync.sv
module zq_tgt_sync #(
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_open_i,
   input  logic [CODE_W-1:0] tgt_i,
   output logic [CODE_W-1:0] tgt_o
);
   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

   logic [CODE_W-1:0] raw;
   logic [CODE_W-1:0] stg [SYNC_STAGES];

   assign raw = ref_open_i ? CODE_MAX : tgt_i;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= raw;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign tgt_o = stg[SYNC_STAGES-1];

   // R6: an open reference forces the all-ones request into the first stage
   p_open_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ref_open_i) |-> (stg[0] == CODE_MAX));
endmodule

// File: rtl/zq_pacer.sv
module zq_pacer #(
   parameter int STEP_GAP = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic grant_o
);
   if (STEP_GAP <= 1) begin : g_free
      assign grant_o = req_i;
   end else begin : g_timed
      localparam int CW = $clog2(STEP_GAP);
      localparam logic [CW-1:0] RELOAD = CW'(STEP_GAP - 1);
      logic [CW-1:0] cool_q;

      assign grant_o = req_i && (cool_q == '0);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cool_q <= '0;
         else if (grant_o)        cool_q <= RELOAD;
         else if (cool_q != '0)   cool_q <= cool_q - 1'b1;
      end

      // R5: no grant on the edge right after a grant
      p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(grant_o) |-> !grant_o);
   end
endmodule

// File: rtl/zq_stepper.sv
module zq_stepper #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hiz_i,
   input  logic [CODE_W-1:0] tgt_i,
   input  logic              grant_i,
   output logic              req_o,
   output logic [CODE_W-1:0] code_o
);
   logic [CODE_W-1:0] code_q;
   logic              go_up;

   assign go_up  = tgt_i > code_q;
   assign req_o  = hiz_i && (code_q != tgt_i);
   assign code_o = code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       code_q <= '0;
      else if (grant_i) code_q <= go_up ? code_q + 1'b1 : code_q - 1'b1;
   end

   p_hiz_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(hiz_i) |-> $stable(code_q));

   p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q != $past(code_q)) |->
         ((code_q == $past(code_q) + CODE_W'(1)) || (code_q == $past(code_q) - CODE_W'(1))));

   p_no_overshoot_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q > $past(code_q)) |-> (code_q <= $past(tgt_i)));

   p_no_overshoot_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q < $past(code_q)) |-> (code_q >= $past(tgt_i)));

   p_hold_at_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(code_q) == $past(tgt_i)) |-> $stable(code_q));
endmodule

// File: rtl/zq_imp_seq.sv
module zq_imp_seq
   import zq_imp_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int STEP_GAP    = 8,
   parameter int WALK_LIMIT  = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hiz_i,
   input  logic              ref_open_i,
   input  logic [CODE_W-1:0] tgt_code_i,
   output logic [CODE_W-1:0] code_o,
   output logic              done_o
);
   localparam int unsigned WALK = zq_walk_cycles(CODE_W, STEP_GAP, SYNC_STAGES);

   if (CODE_W < 2 || CODE_W > 16) begin : g_bad_width
      $error("zq_imp_seq: CODE_W out of range");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("zq_imp_seq: SYNC_STAGES must be at least 1");
   end
   if (STEP_GAP < 1) begin : g_bad_gap
      $error("zq_imp_seq: STEP_GAP must be at least 1");
   end
   if (WALK > WALK_LIMIT) begin : g_bad_walk
      $error("zq_imp_seq: full walk exceeds WALK_LIMIT");
   end

   logic [CODE_W-1:0] eff_tgt;
   logic              req;
   logic              grant;

   zq_tgt_sync #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_open_i (ref_open_i),
      .tgt_i      (tgt_code_i),
      .tgt_o      (eff_tgt)
   );

   zq_pacer #(.STEP_GAP(STEP_GAP)) u_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .grant_o (grant)
   );

   zq_stepper #(.CODE_W(CODE_W)) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .hiz_i   (hiz_i),
      .tgt_i   (eff_tgt),
      .grant_i (grant),
      .req_o   (req),
      .code_o  (code_o)
   );

   assign done_o = (code_o == eff_tgt);

   if (STEP_GAP > 1) begin : g_gap_chk
      // R5: the code stays put on the edge right after a change
      p_step_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (code_o != $past(code_o)) |=> $stable(code_o));
   end

   // R8: a change happens only while the done flag was low
   p_done_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done_o) && $stable(eff_tgt) |-> $stable(code_o));
endmodule

// File: tb/zq_imp_seq_bench.sv
module zq_imp_seq_bench;
   localparam int W     = 8;
   localparam int SYNC  = 2;
   localparam int GAP   = 8;
   localparam int MAXC  = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         hiz = 1'b0;
   logic         ropen = 1'b0;
   logic [W-1:0] tgt = '0;
   logic [W-1:0] code;
   logic         done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   zq_imp_seq #(.CODE_W(W), .SYNC_STAGES(SYNC), .STEP_GAP(GAP)) u_zq_imp_seq (
      .clk(clk), .rst_n(rst_n), .hiz_i(hiz), .ref_open_i(ropen),
      .tgt_code_i(tgt), .code_o(code), .done_o(done));

   // behavioural reference
   int m_code, m_cool;
   int m_pipe[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_code = 0; m_cool = 0;
         m_pipe = {};
         for (int i = 0; i < SYNC; i++) m_pipe.push_back(0);
      end else begin
         int eff;
         eff = m_pipe[SYNC-1];
         if (hiz && m_code != eff && m_cool == 0) begin
            m_code = (eff > m_code) ? m_code + 1 : m_code - 1;
            m_cool = GAP - 1;
         end else if (m_cool > 0) begin
            m_cool = m_cool - 1;
         end
         void'(m_pipe.pop_back());
         m_pipe.push_front(ropen ? MAXC : int'(tgt));
      end
   end

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // one cycle: compare against the model, then drive the next inputs
   task automatic cyc_drive(input bit h, input bit o, input int t);
      @(negedge clk);
      chk(int'(code) == m_code, "R3/R4 code vs model", int'(code), m_code);
      chk(int'(done) == int'(m_code == m_pipe[SYNC-1]), "R8 done vs model",
          int'(done), int'(m_code == m_pipe[SYNC-1]));
      hiz = h; ropen = o; tgt = W'(t);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; hiz = 1'b0; ropen = 1'b0; tgt = '0;
      @(negedge clk);
      chk(code == '0, "R1 code during reset", int'(code), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_run();
   end

   initial begin
      int last_chg, prev, n;
      do_reset();
      cyc_drive(0, 0, 0);
      chk(code == '0, "R1 code after reset", int'(code), 0);

      // R2: request 50 but outputs driving: code frozen
      for (int i = 0; i < 30; i++) cyc_drive(0, 0, 50);
      chk(code == '0, "R2 frozen without hiz", int'(code), 0);

      // rise to 10 with hiz held, record step spacing (R5)
      last_chg = -1; prev = int'(code);
      for (int i = 0; i < 120; i++) begin
         cyc_drive(1, 0, 10);
         if (int'(code) != prev) begin
            if (last_chg >= 0)
               chk(i - last_chg >= GAP, "R5 step spacing", i - last_chg, GAP);
            last_chg = i; prev = int'(code);
         end
      end
      chk(code == W'(10) && done, "R4 settled at 10", int'(code), 10);

      // R10: hold at target with hiz high
      for (int i = 0; i < 20; i++) cyc_drive(1, 0, 10);
      chk(code == W'(10), "R10 hold at target", int'(code), 10);

      // R7: request 11, latency through the stages
      cyc_drive(1, 0, 11);
      cyc_drive(1, 0, 11);
      chk(done == 1'b1, "R7 done still high after one edge", int'(done), 1);
      cyc_drive(1, 0, 11);
      chk(done == 1'b0, "R7 done low after SYNC edges", int'(done), 0);
      cyc_drive(1, 0, 11);
      chk(code == W'(11), "R7 step after request arrives", int'(code), 11);

      // R4: move down to 3
      for (int i = 0; i < 100; i++) cyc_drive(1, 0, 3);
      chk(code == W'(3), "R4 settled down at 3", int'(code), 3);

      // random hiz and changing requests: model compared every cycle
      for (int i = 0; i < 3000; i++) begin
         if (i % 97 == 0) n = $urandom_range(0, 40);
         cyc_drive(1'($urandom_range(0, 1)), 1'(i % 500 > 480), n);
      end

      // R6, R9: full walk from reset with open reference
      do_reset();
      n = 0;
      while (!(done && code == W'(MAXC)) && n < 2100) begin
         cyc_drive(1, 1, 7);
         n++;
      end
      chk(code == W'(MAXC), "R6 open reference reaches all ones", int'(code), MAXC);
      chk(n <= 2048, "R9 walk within 2048 cycles", n, 2048);

      finish_run();
   end
endmodule